// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block turns the system clock into the serial clock of an SPI master. It also gives a shift engine two one-cycle strobes. The divide ratio is set by two codes. A 2-bit prescaler code picks a small odd-or-two factor, and a 4-bit scaler code picks a mostly power-of-two factor. The two factors are multiplied. An optional double-rate flag halves the resulting period. A polarity input sets the level SCK rests at.

A frame runs while the `run` input is high. The divide settings and the polarity are captured at the first cycle of a frame. After that they stay fixed until `run` drops and rises again. While `run` is low, SCK rests at the idle level and no strobe fires. A shift engine uses `launch` to drive its next bit out and `sample` to capture the incoming bit.

The controller is a three-state machine:
- **IDLE**: SCK at rest. Leaves for LEAD when `run` is seen high (start).
- **LEAD**: SCK at the active level. Goes to TRAIL when the leading phase expires (trailing edge), or back to IDLE when `run` is low (abort).
- **TRAIL**: SCK back at the idle level. Goes to LEAD when the trailing phase expires (next leading edge), or to IDLE when `run` is low (stop).

Top module: `sck_rate_gen`

## Requirements
- R1: While `rst` is high, each clock edge sets `sck` to the value of `cpol` and holds `launch` and `sample` low.
- R2: At every clock edge where `run` is low, the next `sck` value equals `cpol` sampled at that edge, and neither strobe fires.
- R3: Prescaler codes 0, 1, 2 and 3 select factors 2, 3, 5 and 7.
- R4: Scaler code c selects factor 2·(c+1) for c = 0, 1, 2, and 2^c for c = 3 to 15.
- R5: One SCK period lasts T = prescaler × scaler system clocks when `dbl_rate` is 0, and T/2 when `dbl_rate` is 1. The shortest period is 2 clocks.
- R6: The leading (active) phase lasts T − floor(T/2) clocks and the trailing (idle-level) phase lasts floor(T/2) clocks. So with `dbl_rate` 0 both halves are exactly T/2.
- R7: `launch` is high for exactly one clock, in the cycle SCK moves to its active level. `sample` is high for exactly one clock, in the cycle SCK returns to its idle level. The two strobes are never high together.
- R8: When `run` is first sampled high, SCK goes active and `launch` fires in the following cycle.
- R9: Changes to `pre_code`, `scl_code`, `dbl_rate` or `cpol` during a frame do not change the running frame. They apply from the next frame start.
- R10: If `run` drops during a leading phase, SCK returns to idle in the next cycle, and no `sample` strobe fires.
- R11: The active level of SCK is the inverse of `cpol` captured at the frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Frame enable; SCK toggles only while high |
| pre_code | input | 2 | Prescaler selection code |
| scl_code | input | 4 | Scaler selection code |
| dbl_rate | input | 1 | Double-rate flag; halves the SCK period |
| cpol | input | 1 | Idle level of SCK |
| sck | output | 1 | Serial clock |
| launch | output | 1 | One-cycle strobe on the leading SCK edge |
| sample | output | 1 | One-cycle strobe on the trailing SCK edge |

## Verification
In a frame, an expiring phase and the loss of `run` can fall in the same cycle. The bench drops `run` in the middle of a long leading phase and expects SCK at idle with no `sample` one cycle later. At the fastest setting (prescaler 2, scaler 2, double rate), `launch` and `sample` alternate on every cycle. The bench checks that both phases last one clock and that the strobes never overlap. A configuration change is also applied in the same cycle as a `launch`. The bench judges it by measuring the phase length that follows, and then the phase length in the next frame.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } sck_state_e;

    // Prescaler factor: odd primes above the first entry.
    function automatic int unsigned pre_div(input int unsigned code);
        case (code)
            0:       return 2;
            1:       return 3;
            2:       return 5;
            default: return 7;
        endcase
    endfunction

    // Scaler factor: linear steps for the lowest three codes, then powers of two.
    function automatic int unsigned scl_div(input int unsigned code);
        if (code < 3)
            return 2 * (code + 1);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/rate_decode.sv
module rate_decode #(
    parameter int PRE_W = 2,
    parameter int SCL_W = 4,
    parameter int CNT_W = 18
) (
    input  logic [PRE_W-1:0] pre_code,
    input  logic [SCL_W-1:0] scl_code,
    input  logic             dbl_rate,
    output logic [CNT_W-1:0] lead_len,
    output logic [CNT_W-1:0] trail_len
);
    import sck_gen_pkg::*;

    int unsigned period;

    always_comb begin
        period = pre_div(32'(pre_code)) * scl_div(32'(scl_code));
        if (dbl_rate)
            period = period >> 1;
        // Odd periods give the extra clock to the leading phase.
        lead_len  = CNT_W'(period - (period >> 1));
        trail_len = CNT_W'(period >> 1);
    end

    // Every phase must last at least one clock (R5 shortest period).
    always_comb begin
        a_len_nonzero_r5: assert (lead_len != '0);
    end

endmodule

// File: rtl/half_timer.sv
module half_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    p_count_down_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_load_value_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val) - 1'b1));

endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen #(
    parameter int PRE_W = 2,
    parameter int SCL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [SCL_W-1:0] scl_code,
    input  logic             dbl_rate,
    input  logic             cpol,
    output logic             sck,
    output logic             launch,
    output logic             sample
);
    import sck_gen_pkg::*;

    // Widest product: factor 7 (3 bits) times the largest scaler power.
    localparam int CNT_W = 3 + (2 ** SCL_W) - 1;

    sck_state_e       state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [SCL_W-1:0] scl_q;
    logic             dbl_q;
    logic             cpol_q;

    logic [PRE_W-1:0] pre_sel;
    logic [SCL_W-1:0] scl_sel;
    logic             dbl_sel;
    logic             pol_sel;
    logic [CNT_W-1:0] lead_len, trail_len;
    logic             expired;
    logic             enter_lead, enter_trail;
    logic             frame_start;

    // Settings come from the pins only while idle; captured values rule a frame.
    assign frame_start = (state_q == ST_IDLE) && run;
    assign pre_sel = (state_q == ST_IDLE) ? pre_code : pre_q;
    assign scl_sel = (state_q == ST_IDLE) ? scl_code : scl_q;
    assign dbl_sel = (state_q == ST_IDLE) ? dbl_rate : dbl_q;
    assign pol_sel = (state_q == ST_IDLE) ? cpol     : cpol_q;

    rate_decode #(
        .PRE_W (PRE_W),
        .SCL_W (SCL_W),
        .CNT_W (CNT_W)
    ) u_decode (
        .pre_code  (pre_sel),
        .scl_code  (scl_sel),
        .dbl_rate  (dbl_sel),
        .lead_len  (lead_len),
        .trail_len (trail_len)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = run ? ST_LEAD : ST_IDLE;
            ST_LEAD:  state_d = !run ? ST_IDLE : (expired ? ST_TRAIL : ST_LEAD);
            ST_TRAIL: state_d = !run ? ST_IDLE : (expired ? ST_LEAD : ST_TRAIL);
            default:  state_d = ST_IDLE;
        endcase
    end

    assign enter_lead  = (state_d == ST_LEAD)  && (state_q != ST_LEAD);
    assign enter_trail = (state_d == ST_TRAIL) && (state_q == ST_LEAD);

    half_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (enter_lead || enter_trail),
        .load_val (enter_lead ? lead_len : trail_len),
        .expired  (expired)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Frame configuration capture.
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            scl_q  <= '0;
            dbl_q  <= 1'b0;
            cpol_q <= 1'b0;
        end else if (frame_start) begin
            pre_q  <= pre_code;
            scl_q  <= scl_code;
            dbl_q  <= dbl_rate;
            cpol_q <= cpol;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            sck    <= cpol;
            launch <= 1'b0;
            sample <= 1'b0;
        end else begin
            unique case (state_d)
                ST_LEAD:  sck <= !pol_sel;
                ST_TRAIL: sck <= pol_sel;
                default:  sck <= cpol;
            endcase
            launch <= enter_lead;
            sample <= enter_trail;
        end
    end

    p_idle_when_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sck == $past(cpol) && !launch && !sample));

    p_strobe_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(launch && sample));

    p_launch_on_edge_r7: assert property (@(posedge clk) disable iff (rst)
        launch |-> (sck != $past(sck)));

    p_sample_on_edge_r7: assert property (@(posedge clk) disable iff (rst)
        sample |-> (sck != $past(sck)));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> ($stable(pre_q) && $stable(scl_q) && $stable(dbl_q) && $stable(cpol_q)));

    p_active_level_r11: assert property (@(posedge clk) disable iff (rst)
        launch |-> (sck == !cpol_q));

endmodule

// File: tb/tb_sck_rate_gen.sv
`timescale 1ns/1ps
module tb_sck_rate_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       run;
    logic [1:0] pre_code;
    logic [3:0] scl_code;
    logic       dbl_rate;
    logic       cpol;
    logic       sck, launch, sample;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sck_rate_gen dut (
        .clk (clk), .rst (rst), .run (run), .pre_code (pre_code),
        .scl_code (scl_code), .dbl_rate (dbl_rate), .cpol (cpol),
        .sck (sck), .launch (launch), .sample (sample)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_period(input int pc, input int sc, input int d);
        int p, s, t;
        p = (pc == 0) ? 2 : 2 * pc + 1;
        s = (sc < 3) ? 2 * sc + 2 : 2 ** sc;
        t = p * s;
        if (d != 0) t = t / 2;
        return t;
    endfunction

    // Counts negedges from the current strobe until the other strobe appears.
    task automatic count_phase(input bit want_sample, output int n, output bit extra);
        n = 1;
        extra = 1'b0;
        for (int g = 0; g < 150000; g++) begin
            @(negedge clk);
            if (want_sample ? sample : launch) break;
            if (launch || sample) extra = 1'b1;
            n++;
        end
    endtask

    task automatic measure(input int pc, input int sc, input int d, input int c);
        int t, n1, n2;
        bit ex1, ex2;
        t = exp_period(pc, sc, d);
        run = 1'b0; pre_code = 2'(pc); scl_code = 4'(sc); dbl_rate = 1'(d); cpol = 1'(c);
        @(negedge clk); @(negedge clk);
        chk(sck == 1'(c) && !launch && !sample, "R2 idle level", int'(sck), c);
        run = 1'b1;
        @(negedge clk);
        chk(launch == 1'b1, "R8 launch after run", int'(launch), 1);
        chk(sck == !1'(c), "R11 active level", int'(sck), 1 - c);
        count_phase(1'b1, n1, ex1);
        chk(n1 == t - t / 2, "R3 R4 R6 leading phase", n1, t - t / 2);
        chk(sck == 1'(c) && !ex1, "R7 sample at return to idle", int'(sck), c);
        count_phase(1'b0, n2, ex2);
        chk(n2 == t / 2 && !ex2, "R6 trailing phase", n2, t / 2);
        chk(n1 + n2 == t, "R3 R4 R5 period", n1 + n2, t);
        run = 1'b0;
        @(negedge clk);
        chk(sck == 1'(c) && !launch && !sample, "R2 stop", int'(sck), c);
    endtask

    initial begin
        int n;
        bit ex;
        rst = 1'b1; run = 1'b0; pre_code = '0; scl_code = '0; dbl_rate = 1'b0; cpol = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sck == 1'b1 && !launch && !sample, "R1 reset state", int'(sck), 1);
        rst = 1'b0;

        // Sweep over the small-scaler corner of the configuration space.
        for (int pc = 0; pc < 4; pc++)
            for (int sc = 0; sc < 5; sc++)
                for (int d = 0; d < 2; d++)
                    for (int c = 0; c < 2; c++)
                        measure(pc, sc, d, c);

        // Slow setting and fastest setting.
        measure(3, 9, 0, 0);
        measure(0, 0, 1, 1);

        // R9: change configuration in the launch cycle; running frame keeps old rate.
        run = 1'b0; pre_code = 2'd1; scl_code = 4'd2; dbl_rate = 1'b0; cpol = 1'b0;
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        pre_code = 2'd3; scl_code = 4'd3; cpol = 1'b1;
        count_phase(1'b1, n, ex);
        chk(n == 9, "R9 running frame keeps rate", n, 9);
        chk(sck == 1'b0, "R9 running frame keeps polarity", int'(sck), 0);
        run = 1'b0;
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        chk(sck == 1'b0 && launch, "R9 new polarity at next frame", int'(sck), 0);
        count_phase(1'b1, n, ex);
        chk(n == 28, "R9 new rate at next frame", n, 28);

        // R10: abort in the middle of a long leading phase.
        run = 1'b0; pre_code = 2'd3; scl_code = 4'd4; cpol = 1'b0;
        @(negedge clk);
        run = 1'b1;
        repeat (10) @(negedge clk);
        chk(sck == 1'b1, "R10 mid-phase active", int'(sck), 1);
        run = 1'b0;
        @(negedge clk);
        chk(sck == 1'b0 && !sample, "R10 abort to idle", int'(sck), 0);
        ex = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (sample || launch || sck) ex = 1'b1;
        end
        chk(!ex, "R10 no strobe after abort", int'(ex), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule